// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This controller sits on the host side of an imaging analog front end and walks it through its mandatory start-up procedure once supply rails are stable. After a start strobe it hands six 16-bit control words, one at a time, to an external serial shift master. The six words hold the front end in reset, release it, load configuration, start the offset calibration, end the calibration, and load the final configuration. Two of the gaps between words are timed in vertical video periods and not in clock cycles.

A word is only launched during vertical blanking, only while the serial master is idle, and only after the master has acknowledged the previous word. When the last word has been acknowledged, the sequencer raises a completion flag. The timing generator and the camera processor use this flag as their permission to start. The flag stays high until the next reset. The serial shifting itself lies outside this block.

Top module: `pwrup_seq`

## Requirements
- R1: After reset (`rst_ni` low), and until a start is accepted, `send_o` and `seq_done_o` are 0 and `word_o` is 0.
- R2: A one-cycle `start_i` pulse in the idle state begins the sequence. Without a start, no word is ever sent.
- R3: Exactly six words are sent, in this order. Bit 4 is the run bit and bit 3 is the calibrate bit. The two control-register words carry `CTRL_BASE` = 0x0002 with both of those bits cleared.
  - Word 0: base with the run bit clear (0x0002).
  - Word 1: base with the run bit set (0x0012).
  - Word 2: `CFG_WORD` (0x0401).
  - Word 3: base with the run and calibrate bits set (0x001A).
  - Word 4: base with the run bit set (0x0012).
  - Word 5: `FINAL_WORD` (0x0803).
- R4: `send_o` is a single-cycle pulse. It is launched only at an edge where `busy_i` is low. The next word waits for an `xfer_done_i` pulse that acknowledges the previous one.
- R5: A word is launched only at an edge where `blank_i` is high. While `blank_i` stays low, nothing is sent.
- R6: After word 3 is acknowledged, word 4 is launched no earlier than the edge after the (`OFS_WAIT`+1)-th `vtick_i` pulse. Ticks seen before the acknowledgement do not count. With the defaults, 5 ticks fall between the launches of word 3 and word 4.
- R7: After word 4 is acknowledged, word 5 waits the same way for `SETTLE_WAIT`+1 ticks. With the defaults, 2 ticks fall between the launches of word 4 and word 5.
- R8: `seq_done_o` rises in the cycle after word 5 is acknowledged. It then stays high until reset, and no further word is sent.
- R9: A `start_i` pulse while the sequence runs or after it has completed has no effect: there is no restart, no extra word, and no change in order.
- R10: `word_o` holds the last launched word between launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| vtick_i | input | 1 | One-cycle pulse at each vertical period |
| blank_i | input | 1 | High outside the active video period |
| busy_i | input | 1 | Serial master is shifting |
| xfer_done_i | input | 1 | Serial master finished a word, one cycle |
| word_o | output | 16 | Word for the serial master |
| send_o | output | 1 | Launch strobe for `word_o`, one cycle |
| seq_done_o | output | 1 | Sequence complete |

## Verification
A free-running video pattern (a tick every 40 cycles with a 12-cycle blanking window) drives a full sequence. That run shows the word order and values, and the tick counts between the calibration words, which separate counting from the acknowledgement from counting from the launch. Holding blanking low and stalling the master's acknowledgement show that the launch gates on blanking and on the handshake, not on time. Start pulses issued mid-sequence and after completion, and a reset during the calibration wait, show that the sequence cannot be restarted and that reset alone rearms it.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;
  localparam int unsigned NUM_WORDS = 6;
  localparam int unsigned IDX_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_ACK,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  typedef enum logic [IDX_W-1:0] {
    W_RST_LO  = 3'd0,
    W_RST_HI  = 3'd1,
    W_CFG     = 3'd2,
    W_OFS_SET = 3'd3,
    W_OFS_CLR = 3'd4,
    W_FINAL   = 3'd5
  } word_id_e;
endpackage

// File: rtl/pwrup_seq_words.sv
module pwrup_seq_words
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned     WORD_W     = 16,
  parameter logic [WORD_W-1:0] CTRL_BASE  = 16'h0002,
  parameter int unsigned     RST_BIT    = 4,
  parameter int unsigned     OFS_BIT    = 3,
  parameter logic [WORD_W-1:0] CFG_WORD   = 16'h0401,
  parameter logic [WORD_W-1:0] FINAL_WORD = 16'h0803
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] RST_M = WORD_W'(1) << RST_BIT;
  localparam logic [WORD_W-1:0] OFS_M = WORD_W'(1) << OFS_BIT;
  localparam logic [WORD_W-1:0] BASE  = CTRL_BASE & ~(RST_M | OFS_M);

  logic [WORD_W-1:0] tbl [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_tbl
    if (g == int'(W_CFG)) begin : g_cfg
      assign tbl[g] = CFG_WORD;
    end else if (g == int'(W_FINAL)) begin : g_fin
      assign tbl[g] = FINAL_WORD;
    end else begin : g_ctrl
      localparam logic [WORD_W-1:0] RUN = (g == int'(W_RST_LO)) ? '0 : RST_M;
      localparam logic [WORD_W-1:0] CAL = (g == int'(W_OFS_SET)) ? OFS_M : '0;
      assign tbl[g] = BASE | RUN | CAL;
    end
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (idx_i == IDX_W'(i)) word_o = tbl[i];
  end
endmodule

// File: rtl/pwrup_seq_timer.sv
module pwrup_seq_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;

  // target counts completed periods; expiry on tick number target+1
  assign expire_o = armed_q & tick_i & (cnt_q == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      tgt_q   <= '0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      tgt_q   <= target_i;
    end else if (armed_q && tick_i) begin
      if (cnt_q == tgt_q) armed_q <= 1'b0;
      else                cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned OFS_WAIT    = 4,
  parameter int unsigned SETTLE_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              blank_i,
  input  logic              busy_i,
  input  logic              ack_i,
  input  logic              expire_i,
  input  logic [WORD_W-1:0] next_word_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  target_o,
  output logic              send_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  seq_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              send_q, send_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    send_d   = 1'b0;
    word_d   = word_q;
    load_o   = 1'b0;
    target_o = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_ISSUE;
          idx_d = '0;
        end
      end
      ST_ISSUE: begin
        if (blank_i && !busy_i) begin
          send_d = 1'b1;
          word_d = next_word_i;
          st_d   = ST_ACK;
        end
      end
      ST_ACK: begin
        // acknowledge accepted only once the launch pulse is gone
        if (ack_i && !send_q) begin
          if (idx_q == W_FINAL) begin
            st_d = ST_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
            if (idx_q == W_OFS_SET) begin
              load_o   = 1'b1;
              target_o = CNT_W'(OFS_WAIT);
              st_d     = ST_HOLD;
            end else if (idx_q == W_OFS_CLR) begin
              load_o   = 1'b1;
              target_o = CNT_W'(SETTLE_WAIT);
              st_d     = ST_HOLD;
            end else begin
              st_d = ST_ISSUE;
            end
          end
        end
      end
      ST_HOLD: begin
        if (expire_i) st_d = ST_ISSUE;
      end
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      send_q <= 1'b0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      send_q <= send_d;
      word_q <= word_d;
    end
  end

  assign idx_o  = idx_q;
  assign send_o = send_q;
  assign word_o = word_q;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned       WORD_W      = 16,
  parameter logic [WORD_W-1:0] CTRL_BASE   = 16'h0002,
  parameter int unsigned       RST_BIT     = 4,
  parameter int unsigned       OFS_BIT     = 3,
  parameter logic [WORD_W-1:0] CFG_WORD    = 16'h0401,
  parameter logic [WORD_W-1:0] FINAL_WORD  = 16'h0803,
  parameter int unsigned       OFS_WAIT    = 4,
  parameter int unsigned       SETTLE_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vtick_i,
  input  logic              blank_i,
  input  logic              busy_i,
  input  logic              xfer_done_i,
  output logic [WORD_W-1:0] word_o,
  output logic              send_o,
  output logic              seq_done_o
);
  localparam int unsigned MAX_WAIT = (OFS_WAIT > SETTLE_WAIT) ? OFS_WAIT : SETTLE_WAIT;
  localparam int unsigned CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] next_word;
  logic              load;
  logic [CNT_W-1:0]  target;
  logic              expire;

  pwrup_seq_words #(
    .WORD_W    (WORD_W),
    .CTRL_BASE (CTRL_BASE),
    .RST_BIT   (RST_BIT),
    .OFS_BIT   (OFS_BIT),
    .CFG_WORD  (CFG_WORD),
    .FINAL_WORD(FINAL_WORD)
  ) u_words (
    .idx_i (idx),
    .word_o(next_word)
  );

  pwrup_seq_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .target_i(target),
    .tick_i  (vtick_i),
    .expire_o(expire)
  );

  pwrup_seq_ctrl #(
    .WORD_W     (WORD_W),
    .CNT_W      (CNT_W),
    .OFS_WAIT   (OFS_WAIT),
    .SETTLE_WAIT(SETTLE_WAIT)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .blank_i    (blank_i),
    .busy_i     (busy_i),
    .ack_i      (xfer_done_i),
    .expire_i   (expire),
    .next_word_i(next_word),
    .idx_o      (idx),
    .load_o     (load),
    .target_o   (target),
    .send_o     (send_o),
    .word_o     (word_o),
    .done_o     (seq_done_o)
  );
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              blank_i,
  input logic              busy_i,
  input logic [WORD_W-1:0] word_o,
  input logic              send_o,
  input logic              seq_done_o
);
  AST_SEND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |=> !send_o); // R4

  AST_SEND_MASTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_o) |-> !$past(busy_i)); // R4

  AST_SEND_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_o) |-> $past(blank_i)); // R5

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |=> seq_done_o); // R8

  AST_NO_SEND_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> !send_o); // R8

  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !send_o |-> $stable(word_o)); // R10
endmodule

bind pwrup_seq pwrup_seq_chk #(.WORD_W(WORD_W)) u_pwrup_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .blank_i   (blank_i),
  .busy_i    (busy_i),
  .word_o    (word_o),
  .send_o    (send_o),
  .seq_done_o(seq_done_o)
);

// File: tb/pwrup_seq_bench.sv
module pwrup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VPER   = 40;
  localparam int VBLANK = 12;
  localparam int MLAT   = 5;
  localparam int OFS_N  = 4;
  localparam int SET_N  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, vtick = 1'b0, blank = 1'b0, busy = 1'b0, xdone = 1'b0;
  logic [15:0] word;
  logic send, done_o;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_seq u_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vtick_i(vtick),
    .blank_i(blank), .busy_i(busy), .xfer_done_i(xdone),
    .word_o(word), .send_o(send), .seq_done_o(done_o)
  );

  // video pattern
  bit force_low = 1'b0;
  int phase = 0;
  initial forever begin
    @(negedge clk);
    phase = (phase + 1) % VPER;
    vtick = (phase == 0);
    blank = !force_low && (phase < VBLANK);
  end

  int   tick_cnt = 0;
  logic blank_seen = 1'b0;
  always @(posedge clk) begin
    if (vtick) tick_cnt <= tick_cnt + 1;
    blank_seen <= blank;
  end

  // serial master model
  logic [15:0] cap_w [16];
  int   cap_t [16];
  int   ncap = 0;
  int   blank_bad = 0;
  bit   hold = 1'b0;
  initial forever begin
    @(negedge clk);
    if (send === 1'b1) begin
      if (ncap < 16) begin
        cap_w[ncap] = word;
        cap_t[ncap] = tick_cnt;
      end
      ncap++;
      if (!blank_seen) blank_bad++;
      busy = 1'b1;
      repeat (MLAT) @(negedge clk);
      while (hold) @(negedge clk);
      busy  = 1'b0;
      xdone = 1'b1;
      @(negedge clk);
      xdone = 1'b0;
    end
  end

  function automatic logic [15:0] exp_w(int i);
    case (i)
      0: return 16'h0002;
      1: return 16'h0012;
      2: return 16'h0401;
      3: return 16'h001A;
      4: return 16'h0012;
      default: return 16'h0803;
    endcase
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic do_reset();
    while (busy || xdone) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    ncap = 0;
    blank_bad = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(int limit);
    for (int i = 0; i < limit && !done_o; i++) @(negedge clk);
  endtask

  task automatic wait_ncap(int n, int limit);
    for (int i = 0; i < limit && ncap < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 send after reset", send, 0);
    chk("R1 done after reset", done_o, 0);
    chk("R1 word after reset", word, 0);
  endtask

  task automatic t_no_start();
    do_reset();
    repeat (100) @(negedge clk);
    chk("R2 no word without start", ncap, 0);
    chk("R1 done stays low idle", done_o, 0);
  endtask

  task automatic t_full();
    do_reset();
    pulse_start();
    wait_done(3000);
    chk("R8 done after sequence", done_o, 1);
    chk("R3 word count", ncap, 6);
    for (int i = 0; i < 6; i++) chk($sformatf("R3 word %0d", i), cap_w[i], exp_w(i));
    chk("R6 ticks between cal set and clear", cap_t[4] - cap_t[3], OFS_N + 1);
    chk("R7 ticks between cal clear and final", cap_t[5] - cap_t[4], SET_N + 1);
    chk("R5 launches inside blanking", blank_bad, 0);
    chk("R10 word held after last send", word, exp_w(5));
    pulse_start();
    repeat (200) @(negedge clk);
    chk("R9 start after done ignored", ncap, 6);
    chk("R8 done sticky", done_o, 1);
  endtask

  task automatic t_restart_ignored();
    do_reset();
    pulse_start();
    wait_ncap(2, 2000);
    pulse_start();
    wait_ncap(4, 2000);
    pulse_start();
    wait_done(3000);
    chk("R9 count with mid starts", ncap, 6);
    for (int i = 0; i < 6; i++) chk($sformatf("R9 order word %0d", i), cap_w[i], exp_w(i));
  endtask

  task automatic t_handshake();
    do_reset();
    hold = 1'b1;
    pulse_start();
    repeat (200) @(negedge clk);
    chk("R4 no next word without ack", ncap, 1);
    chk("R10 word held during stall", word, exp_w(0));
    hold = 1'b0;
    wait_done(3000);
    chk("R4 sequence resumes after ack", ncap, 6);
  endtask

  task automatic t_blank_hold();
    do_reset();
    force_low = 1'b1;
    pulse_start();
    repeat (150) @(negedge clk);
    chk("R5 nothing sent in active video", ncap, 0);
    force_low = 1'b0;
    wait_done(3000);
    chk("R5 sequence after blanking returns", ncap, 6);
    chk("R5 launches inside blanking", blank_bad, 0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    pulse_start();
    wait_ncap(4, 2000);
    do_reset();
    chk("R1 done low after mid reset", done_o, 0);
    repeat (100) @(negedge clk);
    chk("R2 no word after reset without start", ncap, 0);
    pulse_start();
    wait_done(3000);
    chk("R1 restart begins with word 0", cap_w[0], exp_w(0));
    chk("R3 count after restart", ncap, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    t_no_start();
    t_full();
    t_restart_ignored();
    t_handshake();
    t_blank_hold();
    t_reset_mid();
    summary();
    $finish;
  end
endmodule